// File: doc/BRIEF.md
# Segmented Thermometer Decoder with Group Test Overlay

This block turns a binary code into enable lines for a segmented current-steering converter. The upper field of the code drives a two-dimensional matrix of equal-weight unit cells through a row/column thermometer decode. The lower field is decoded on its own into a separate thermometer group. In normal operation, a code value k switches on exactly the first k cells of the matrix in fixed index order, and the switched-on cells always form one unbroken run.

A test-select input places a diagnostic overlay over the normal decode. While it is high, a one-hot address switches on one complete column or one complete row of the matrix, and nothing else. A mode bit chooses between column and row. The summed output of that group can then be measured and compared against the other groups, which takes a number of measurements linear in the matrix side rather than stepping through every code. All outputs are registered.

Top module: `seg_thermo_dec`

## Requirements
- R1: The code splits into an upper field `code_i[CODE_W-1:LOWER_W]` and a lower field `code_i[LOWER_W-1:0]`. Each field is decoded independently of the other.
- R2: With `test_sel_i`=0, `cell_en_o[i]` is 1 exactly when i is less than the upper field value. The cell at row r and column c has index i = r*NUM_COLS + c.
- R3: With `test_sel_i`=0, `lsb_en_o[i]` is 1 exactly when i is less than the lower field value.
- R4: In normal mode, both output vectors hold a single run of ones that starts at bit 0, with no gaps.
- R5: With `test_sel_i`=1 and `col_mode_i`=1, a `col_addr_i` that has exactly bit c set enables every cell in column c across all rows, and no other cell.
- R6: With `test_sel_i`=1 and `col_mode_i`=0, a `row_addr_i` that has exactly bit r set enables every cell in row r across all columns, and no other cell.
- R7: In test mode, if the address for the selected mode has zero bits set or more than one bit set, no cell is enabled.
- R8: In test mode, `lsb_en_o` is all zero and `code_i` has no effect on either output.
- R9: Outputs update on the first rising clock edge after the inputs change, including changes to the test controls. They hold their value until that edge.
- R10: While `rst_ni` is low, both output vectors are all zero. Reset acts asynchronously.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| code_i | input | CODE_W | Binary input code (upper and lower fields) |
| test_sel_i | input | 1 | 1 selects the group test overlay |
| col_mode_i | input | 1 | In test mode: 1 selects a column, 0 selects a row |
| col_addr_i | input | NUM_COLS | One-hot column address |
| row_addr_i | input | NUM_ROWS | One-hot row address |
| cell_en_o | output | NUM_CELLS | Matrix cell enables, index row*NUM_COLS+col |
| lsb_en_o | output | LOWER_CELLS | Lower-field thermometer enables |

## Verification
The bench builds the block with a 6-bit upper field split into 3 row bits and 3 column bits, which gives an 8x8 matrix, and a 4-bit lower field. At this size all 1024 codes can be swept exhaustively. The sweep covers every row and column boundary crossing, and also full scale, where the last cell of the matrix stays off. The small matrix also lets the bench select each of the 8 columns and 8 rows in turn, and apply several invalid addresses, including all-zero, two-hot and all-ones.

// File: rtl/seg_thermo_pkg.sv
package seg_thermo_pkg;
  typedef enum logic {
    GRP_ROW = 1'b0,
    GRP_COL = 1'b1
  } grp_mode_e;
endpackage

// File: rtl/thermo_dec.sv
module thermo_dec #(
  parameter int IN_W  = 3,
  parameter int OUT_N = 7
) (
  input  logic [IN_W-1:0]  bin_i,
  output logic [OUT_N-1:0] therm_o
);
  for (genvar g = 0; g < OUT_N; g++) begin : g_bit
    assign therm_o[g] = (bin_i > IN_W'(g));
  end
endmodule

// File: rtl/matrix_dec.sv
module matrix_dec #(
  parameter int UPPER_W = 6,
  parameter int COL_W   = 3
) (
  input  logic [UPPER_W-1:0]                         upper_i,
  output logic [(1<<(UPPER_W-COL_W))*(1<<COL_W)-1:0] cells_o
);
  localparam int ROW_W    = UPPER_W - COL_W;
  localparam int NUM_COLS = 1 << COL_W;
  localparam int NUM_ROWS = 1 << ROW_W;

  logic [ROW_W-1:0]    row_idx;
  logic [COL_W-1:0]    col_idx;
  logic [NUM_ROWS-1:0] row_full;
  logic [NUM_ROWS-1:0] row_act;
  logic [NUM_COLS-1:0] col_part;

  assign row_idx = upper_i[UPPER_W-1:COL_W];
  assign col_idx = upper_i[COL_W-1:0];

  // rows strictly below the active row are fully on
  thermo_dec #(.IN_W(ROW_W), .OUT_N(NUM_ROWS)) i_row_therm (
    .bin_i   (row_idx),
    .therm_o (row_full)
  );

  // partial fill inside the active row
  thermo_dec #(.IN_W(COL_W), .OUT_N(NUM_COLS)) i_col_therm (
    .bin_i   (col_idx),
    .therm_o (col_part)
  );

  for (genvar r = 0; r < NUM_ROWS; r++) begin : g_row
    assign row_act[r] = (row_idx == ROW_W'(r));
    for (genvar c = 0; c < NUM_COLS; c++) begin : g_col
      assign cells_o[r*NUM_COLS + c] = row_full[r] | (row_act[r] & col_part[c]);
    end
  end
endmodule

// File: rtl/group_overlay.sv
module group_overlay
  import seg_thermo_pkg::*;
#(
  parameter int NUM_ROWS = 8,
  parameter int NUM_COLS = 8
) (
  input  grp_mode_e                    mode_i,
  input  logic [NUM_COLS-1:0]          col_addr_i,
  input  logic [NUM_ROWS-1:0]          row_addr_i,
  output logic [NUM_ROWS*NUM_COLS-1:0] cells_o
);
  logic col_ok;
  logic row_ok;
  logic col_go;
  logic row_go;

  // invalid addresses (none or several bits) select nothing
  assign col_ok = $onehot(col_addr_i);
  assign row_ok = $onehot(row_addr_i);
  assign col_go = (mode_i == GRP_COL) && col_ok;
  assign row_go = (mode_i == GRP_ROW) && row_ok;

  for (genvar r = 0; r < NUM_ROWS; r++) begin : g_row
    for (genvar c = 0; c < NUM_COLS; c++) begin : g_col
      assign cells_o[r*NUM_COLS + c] = (col_go & col_addr_i[c]) | (row_go & row_addr_i[r]);
    end
  end
endmodule

// File: rtl/seg_thermo_dec.sv
module seg_thermo_dec
  import seg_thermo_pkg::*;
#(
  parameter int UPPER_W = 6,
  parameter int COL_W   = 3,
  parameter int LOWER_W = 4,
  localparam int ROW_W       = UPPER_W - COL_W,
  localparam int NUM_COLS    = 1 << COL_W,
  localparam int NUM_ROWS    = 1 << ROW_W,
  localparam int NUM_CELLS   = NUM_ROWS * NUM_COLS,
  localparam int LOWER_CELLS = (1 << LOWER_W) - 1,
  localparam int CODE_W      = UPPER_W + LOWER_W
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic [CODE_W-1:0]      code_i,
  input  logic                   test_sel_i,
  input  logic                   col_mode_i,
  input  logic [NUM_COLS-1:0]    col_addr_i,
  input  logic [NUM_ROWS-1:0]    row_addr_i,
  output logic [NUM_CELLS-1:0]   cell_en_o,
  output logic [LOWER_CELLS-1:0] lsb_en_o
);
  logic [UPPER_W-1:0]     upper;
  logic [LOWER_W-1:0]     lower;
  logic [NUM_CELLS-1:0]   norm_cells;
  logic [NUM_CELLS-1:0]   test_cells;
  logic [LOWER_CELLS-1:0] norm_lsb;
  logic [NUM_CELLS-1:0]   cell_d;
  logic [LOWER_CELLS-1:0] lsb_d;
  grp_mode_e              grp_mode;

  assign upper    = code_i[CODE_W-1:LOWER_W];
  assign lower    = code_i[LOWER_W-1:0];
  assign grp_mode = grp_mode_e'(col_mode_i);

  matrix_dec #(.UPPER_W(UPPER_W), .COL_W(COL_W)) i_matrix (
    .upper_i (upper),
    .cells_o (norm_cells)
  );

  thermo_dec #(.IN_W(LOWER_W), .OUT_N(LOWER_CELLS)) i_lsb_therm (
    .bin_i   (lower),
    .therm_o (norm_lsb)
  );

  group_overlay #(.NUM_ROWS(NUM_ROWS), .NUM_COLS(NUM_COLS)) i_overlay (
    .mode_i     (grp_mode),
    .col_addr_i (col_addr_i),
    .row_addr_i (row_addr_i),
    .cells_o    (test_cells)
  );

  // test mode isolates the matrix group; lower segment stays dark
  always_comb begin
    if (test_sel_i) begin
      cell_d = test_cells;
      lsb_d  = '0;
    end else begin
      cell_d = norm_cells;
      lsb_d  = norm_lsb;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cell_en_o <= '0;
      lsb_en_o  <= '0;
    end else begin
      cell_en_o <= cell_d;
      lsb_en_o  <= lsb_d;
    end
  end
endmodule

// File: rtl/seg_thermo_chk.sv
module seg_thermo_chk #(
  parameter int UPPER_W = 6,
  parameter int COL_W   = 3,
  parameter int LOWER_W = 4,
  localparam int ROW_W       = UPPER_W - COL_W,
  localparam int NUM_COLS    = 1 << COL_W,
  localparam int NUM_ROWS    = 1 << ROW_W,
  localparam int NUM_CELLS   = NUM_ROWS * NUM_COLS,
  localparam int LOWER_CELLS = (1 << LOWER_W) - 1,
  localparam int CODE_W      = UPPER_W + LOWER_W
) (
  input logic                   clk_i,
  input logic                   rst_ni,
  input logic [CODE_W-1:0]      code_i,
  input logic                   test_sel_i,
  input logic                   col_mode_i,
  input logic [NUM_COLS-1:0]    col_addr_i,
  input logic [NUM_ROWS-1:0]    row_addr_i,
  input logic [NUM_CELLS-1:0]   cell_en_o,
  input logic [LOWER_CELLS-1:0] lsb_en_o
);
  logic               past_ok;
  logic [UPPER_W-1:0] upper_v;
  logic [LOWER_W-1:0] lower_v;
  logic               col_one;
  logic               row_one;

  assign upper_v = code_i[CODE_W-1:LOWER_W];
  assign lower_v = code_i[LOWER_W-1:0];
  assign col_one = $onehot(col_addr_i);
  assign row_one = $onehot(row_addr_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) past_ok <= 1'b0;
    else         past_ok <= 1'b1;
  end

  assert_cell_count_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    past_ok && $past(!test_sel_i) |-> $countones(cell_en_o) == int'($past(upper_v)));

  assert_lsb_count_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    past_ok && $past(!test_sel_i) |-> $countones(lsb_en_o) == int'($past(lower_v)));

  assert_contig_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    past_ok && $past(!test_sel_i) |->
      ((cell_en_o & (cell_en_o + NUM_CELLS'(1))) == '0) &&
      ((lsb_en_o & (lsb_en_o + LOWER_CELLS'(1))) == '0));

  assert_col_group_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    past_ok && $past(test_sel_i && col_mode_i && col_one) |-> $countones(cell_en_o) == NUM_ROWS);

  assert_row_group_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    past_ok && $past(test_sel_i && !col_mode_i && row_one) |-> $countones(cell_en_o) == NUM_COLS);

  assert_bad_addr_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    past_ok && $past(test_sel_i && ((col_mode_i && !col_one) || (!col_mode_i && !row_one)))
      |-> cell_en_o == '0);

  assert_lsb_quiet_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    past_ok && $past(test_sel_i) |-> lsb_en_o == '0);
endmodule

bind seg_thermo_dec seg_thermo_chk #(
  .UPPER_W (UPPER_W),
  .COL_W   (COL_W),
  .LOWER_W (LOWER_W)
) i_seg_thermo_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .code_i     (code_i),
  .test_sel_i (test_sel_i),
  .col_mode_i (col_mode_i),
  .col_addr_i (col_addr_i),
  .row_addr_i (row_addr_i),
  .cell_en_o  (cell_en_o),
  .lsb_en_o   (lsb_en_o)
);

// File: tb/test_seg_thermo_dec.sv
module test_seg_thermo_dec;
  localparam int CLK_PERIOD = 10;
  localparam int UPPER_W = 6;
  localparam int COL_W   = 3;
  localparam int LOWER_W = 4;
  localparam int NCOL    = 1 << COL_W;
  localparam int NROW    = 1 << (UPPER_W - COL_W);
  localparam int NC      = NCOL * NROW;
  localparam int NL      = (1 << LOWER_W) - 1;
  localparam int CW      = UPPER_W + LOWER_W;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic [CW-1:0]   code = '0;
  logic            ts = 1'b0;
  logic            cm = 1'b0;
  logic [NCOL-1:0] ca = '0;
  logic [NROW-1:0] ra = '0;
  logic [NC-1:0]   cells;
  logic [NL-1:0]   lsb;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  seg_thermo_dec #(.UPPER_W(UPPER_W), .COL_W(COL_W), .LOWER_W(LOWER_W)) i_seg_thermo_dec (
    .clk_i (clk), .rst_ni (rst_n), .code_i (code), .test_sel_i (ts), .col_mode_i (cm),
    .col_addr_i (ca), .row_addr_i (ra), .cell_en_o (cells), .lsb_en_o (lsb)
  );

  function automatic logic [NC-1:0] ref_cells(int c_in, bit t, bit m,
                                              logic [NCOL-1:0] a_c, logic [NROW-1:0] a_r);
    logic [NC-1:0] v = '0;
    int up = c_in >> LOWER_W;
    if (!t) begin
      for (int i = 0; i < NC; i++) v[i] = (i < up);
    end else if (m) begin
      if ($countones(a_c) == 1)
        for (int r = 0; r < NROW; r++)
          for (int c = 0; c < NCOL; c++) if (a_c[c]) v[r*NCOL + c] = 1'b1;
    end else begin
      if ($countones(a_r) == 1)
        for (int r = 0; r < NROW; r++)
          for (int c = 0; c < NCOL; c++) if (a_r[r]) v[r*NCOL + c] = 1'b1;
    end
    return v;
  endfunction

  function automatic logic [NL-1:0] ref_lsb(int c_in, bit t);
    logic [NL-1:0] v = '0;
    int lo = c_in % (1 << LOWER_W);
    if (!t) for (int i = 0; i < NL; i++) v[i] = (i < lo);
    return v;
  endfunction

  task automatic cmp_cells(string tag, logic [NC-1:0] exp_v);
    n_cmp++;
    if (cells !== exp_v) begin
      n_bad++;
      $display("FAIL %s cells act=%h exp=%h", tag, cells, exp_v);
    end
  endtask

  task automatic cmp_lsb(string tag, logic [NL-1:0] exp_v);
    n_cmp++;
    if (lsb !== exp_v) begin
      n_bad++;
      $display("FAIL %s lsb act=%h exp=%h", tag, lsb, exp_v);
    end
  endtask

  // drive right after a falling edge, check at the next falling edge
  task automatic step(int c_in, bit t, bit m, logic [NCOL-1:0] a_c, logic [NROW-1:0] a_r,
                      string ctag, string ltag);
    logic [NC-1:0] ec;
    logic [NL-1:0] el;
    code = CW'(c_in); ts = t; cm = m; ca = a_c; ra = a_r;
    ec = ref_cells(c_in, t, m, a_c, a_r);
    el = ref_lsb(c_in, t);
    @(negedge clk);
    cmp_cells(ctag, ec);
    cmp_lsb(ltag, el);
    if (!t) begin
      n_cmp++;
      if ((cells & (cells + 1'b1)) != '0 || (lsb & (lsb + 1'b1)) != '0) begin
        n_bad++;
        $display("FAIL R4 non-contiguous act=%h/%h exp=run from bit0", cells, lsb);
      end
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog act=timeout exp=completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    // R10: reset state
    repeat (3) @(negedge clk);
    cmp_cells("R10", '0);
    cmp_lsb("R10", '0);
    rst_n = 1'b1;

    // R1: fields decoded independently
    step(0,            0, 0, '0, '0, "R1", "R1");
    step(15,           0, 0, '0, '0, "R1", "R1");
    step(1 << LOWER_W, 0, 0, '0, '0, "R1", "R1");
    step((63 << LOWER_W), 0, 0, '0, '0, "R1", "R1");

    // R2/R3: exhaustive sweep of every code
    for (int k = 0; k < (1 << CW); k++) step(k, 0, 0, '0, '0, "R2", "R3");
    for (int k = (1 << CW) - 1; k >= 0; k -= 37) step(k, 0, 0, '0, '0, "R2", "R3");

    // R5: each column, with busy code inputs (R8)
    for (int c = 0; c < NCOL; c++) step(1023 - c*5, 1, 1, NCOL'(1) << c, '1, "R5", "R8");
    // R6: each row
    for (int r = 0; r < NROW; r++) step(r*77, 1, 0, '1, NROW'(1) << r, "R6", "R8");

    // R7: invalid addresses
    step(500, 1, 1, '0,        NROW'(1), "R7", "R8");
    step(500, 1, 1, 8'b0001_0100, NROW'(1), "R7", "R8");
    step(500, 1, 1, '1,        NROW'(1), "R7", "R8");
    step(500, 1, 0, NCOL'(1),  '0,       "R7", "R8");
    step(500, 1, 0, NCOL'(1),  8'b1100_0000, "R7", "R8");
    step(500, 1, 0, NCOL'(1),  '1,       "R7", "R8");

    // R8: code changes alone have no effect in test mode
    step(0,    1, 1, NCOL'(4), '0, "R8", "R8");
    step(1023, 1, 1, NCOL'(4), '0, "R8", "R8");

    // R9: latency of one edge, including test-mode exit
    step(200, 0, 0, '0, '0, "R9", "R9");
    code = CW'(900); ts = 1'b0;
    #1;
    cmp_cells("R9", ref_cells(200, 0, 0, '0, '0));
    cmp_lsb("R9", ref_lsb(200, 0));
    @(negedge clk);
    cmp_cells("R9", ref_cells(900, 0, 0, '0, '0));
    ts = 1'b1; cm = 1'b0; ra = NROW'(2);
    #1;
    cmp_cells("R9", ref_cells(900, 0, 0, '0, '0));
    @(negedge clk);
    cmp_cells("R9", ref_cells(900, 1, 0, '0, NROW'(2)));
    step(900, 0, 0, '0, '0, "R9", "R9");

    // R10: asynchronous reset mid-run
    step(1023, 0, 0, '0, '0, "R2", "R3");
    #2 rst_n = 1'b0;
    #1;
    cmp_cells("R10", '0);
    cmp_lsb("R10", '0);
    @(negedge clk);
    cmp_cells("R10", '0);
    rst_n = 1'b1;
    step(333, 0, 0, '0, '0, "R2", "R3");

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule